// File: doc/BRIEF.md
# Stack Word Window

A small untagged store for the words at the top of the stack. Loads and stores that name a word by its offset from the stack pointer use this store in place of the data cache. The block keeps only the current stack-pointer word address, and it keeps no address tag per entry. An access selects its entry directly as (stack pointer + offset) modulo the depth. Accesses through some other base that were found to alias the stack arrive on a redirect path as an absolute word address. The block turns that address back into an offset.

A store writes its word and marks the word valid and dirty. Nothing is fetched first. A load to an absent word goes to memory as a single-word read and does not allocate. When the stack pointer rises, the freed words are dead and are dropped without any write-back. When it falls, the words leaving the far end of the window are scanned one per cycle while the block stalls, and only the dirty ones are written out.

The window covers word addresses [SP, SP+DEPTH). The stack pointer and all addresses are word addresses.

Top module: `stack_word_window`

## Requirements
- R1: After reset no word is valid: stall_o is low, no memory write is issued, and every in-window load misses.
- R2: A store with offset 0..DEPTH-1 writes the word and marks it valid. It raises neither mem_rd_o nor mem_wr_o (write-validate, no fill).
- R3: A load to a valid in-window word raises ld_hit_o and returns the stored data on ld_data_o in the same cycle, with no memory request.
- R4: A load to an absent in-window word raises mem_rd_o with mem_rd_addr_o = SP+offset in the same cycle. It does not allocate, so a repeat load misses again.
- R5: acc_off_i is two's complement. An offset below 0 or at or above DEPTH raises oor_o and leaves the array unchanged. A load becomes a memory read of SP+offset, and a store becomes a same-cycle mem_wr_o of that address with the store data.
- R6: When sp_new_i is above SP, the words in [SP, sp_new_i) that lie in the window become invalid and are never written to memory.
- R7: When sp_new_i is below SP by d, stall_o is high for min(d, DEPTH) cycles, starting the cycle after the update. In cycle k of the stall, the block scans word address SP_old+DEPTH-min(d,DEPTH)+k. It asserts mem_wr_o with that address and the word's data only if the word is dirty, then invalidates it.
- R8: With acc_redir_i high, acc_addr_i is an absolute word address whose offset is acc_addr_i-SP. The access then behaves as in R2 to R5.
- R9: While stall_o is high, acc_req_i and sp_set_i are ignored, and ld_hit_o, oor_o and mem_rd_o stay low.
- R10: A stack-pointer update takes effect from the next cycle. The new value is the base for later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sp_set_i | input | 1 | Load a new stack pointer |
| sp_new_i | input | AW | New stack-pointer word address |
| acc_req_i | input | 1 | Access request |
| acc_we_i | input | 1 | 1 = store, 0 = load |
| acc_off_i | input | OW | Signed word offset from SP |
| acc_redir_i | input | 1 | Use acc_addr_i as an absolute address |
| acc_addr_i | input | AW | Absolute word address for redirected accesses |
| acc_wdata_i | input | DW | Store data |
| stall_o | output | 1 | Spill in progress, inputs ignored |
| oor_o | output | 1 | Access outside the window |
| ld_hit_o | output | 1 | Load served from the array |
| ld_data_o | output | DW | Load data |
| mem_rd_o | output | 1 | Single-word memory read request |
| mem_rd_addr_o | output | AW | Read word address |
| mem_wr_o | output | 1 | Memory word write (spill or out-of-range store) |
| mem_wr_addr_o | output | AW | Write word address |
| mem_wr_data_o | output | DW | Write data |

## Verification
Access results are due in the cycle of the request. These are the load hit and data, the out-of-range flag, the memory read, and the forwarded store. The bench drives each cycle's inputs just after the falling edge and compares them two nanoseconds later, before the rising edge that commits state. A store or a stack-pointer change is seen from the next cycle onward. After a downward move, the behavioural model queues one expected scan slot per leaving word. It pops one slot per cycle from the cycle after the update, so each spill write and the length of the stall are checked in the exact cycle they are due.

// File: rtl/sww_pkg.sv
package sww_pkg;
  typedef enum logic {
    SW_IDLE  = 1'b0,
    SW_SPILL = 1'b1
  } sww_state_e;
endpackage

// File: rtl/sww_locate.sv
module sww_locate #(
  parameter int AW    = 16,
  parameter int OW    = 8,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0] sp_i,
  input  logic [OW-1:0] off_i,
  input  logic          redir_i,
  input  logic [AW-1:0] addr_i,
  output logic          in_win_o,
  output logic [AW-1:0] abs_o,
  output logic [IW-1:0] idx_o
);
  logic [AW-1:0] diff;

  // negative offsets wrap to huge unsigned values and fall out of window
  assign diff     = redir_i ? (addr_i - sp_i) : {{(AW-OW){off_i[OW-1]}}, off_i};
  assign in_win_o = diff < AW'(DEPTH);
  assign abs_o    = sp_i + diff;
  assign idx_o    = abs_o[IW-1:0];
endmodule

// File: rtl/sww_store.sv
module sww_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] acc_idx_i,
  output logic          acc_valid_o,
  output logic [DW-1:0] acc_data_o,
  input  logic          pop_en_i,
  input  logic [IW-1:0] pop_base_i,
  input  logic [IW:0]   pop_len_i,
  input  logic          clr_en_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic          clr_dirty_o,
  output logic [DW-1:0] clr_data_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] valid_q, dirty_q, valid_d, dirty_d, dead;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dead
    logic [IW-1:0] rel;
    assign rel     = IW'(i) - pop_base_i;
    assign dead[i] = pop_en_i && ({1'b0, rel} < pop_len_i);
  end

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (wr_en_i) begin
      valid_d[wr_idx_i] = 1'b1;
      dirty_d[wr_idx_i] = 1'b1;
    end
    if (clr_en_i) begin
      valid_d[clr_idx_i] = 1'b0;
      dirty_d[clr_idx_i] = 1'b0;
    end
    // freed frames win over a same-cycle store
    valid_d &= ~dead;
    dirty_d &= ~dead;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign acc_valid_o = valid_q[acc_idx_i];
  assign acc_data_o  = mem_q[acc_idx_i];
  assign clr_dirty_o = dirty_q[clr_idx_i];
  assign clr_data_o  = mem_q[clr_idx_i];

  p_dirty_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dirty_q & ~valid_q) == '0);
  p_store_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !pop_en_i && !clr_en_i |=> valid_q[$past(wr_idx_i)]);
  p_pop_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_en_i && pop_len_i == (IW+1)'(DEPTH) |=> valid_q == '0);
endmodule

// File: rtl/sww_spill.sv
module sww_spill #(
  parameter int AW    = 16,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_en_i,
  input  logic [AW-1:0] push_base_i,
  input  logic [IW:0]   push_len_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] addr_o
);
  import sww_pkg::*;

  sww_state_e    state_q;
  logic [AW-1:0] base_q;
  logic [IW-1:0] j_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SW_IDLE;
      base_q  <= '0;
      j_q     <= '0;
    end else if (state_q == SW_SPILL) begin
      j_q <= j_q + 1'b1;
      if (j_q == IW'(DEPTH-1)) state_q <= SW_IDLE;
    end else if (push_en_i && push_len_i != '0) begin
      // scan only the oldest push_len words of the old window
      state_q <= SW_SPILL;
      base_q  <= push_base_i;
      j_q     <= IW'((IW+1)'(DEPTH) - push_len_i);
    end
  end

  assign busy_o = state_q == SW_SPILL;
  assign addr_o = base_q + AW'(j_q);
  assign idx_o  = addr_o[IW-1:0];

  p_push_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_en_i |-> !busy_o);
  p_spill_ascends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/stack_word_window.sv
module stack_word_window #(
  parameter int          AW       = 16,
  parameter int          OW       = 8,
  parameter int          DW       = 32,
  parameter int          DEPTH    = 64,
  parameter logic [15:0] SP_RESET = 16'h1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sp_set_i,
  input  logic [AW-1:0] sp_new_i,
  input  logic          acc_req_i,
  input  logic          acc_we_i,
  input  logic [OW-1:0] acc_off_i,
  input  logic          acc_redir_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] acc_wdata_i,
  output logic          stall_o,
  output logic          oor_o,
  output logic          ld_hit_o,
  output logic [DW-1:0] ld_data_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_rd_addr_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_wr_addr_o,
  output logic [DW-1:0] mem_wr_data_o
);
  localparam int IW = $clog2(DEPTH);

  logic [AW-1:0] sp_q, d_up, d_dn, abs_addr, spl_addr;
  logic [IW:0]   len_up, len_dn;
  logic [IW-1:0] acc_idx, spl_idx;
  logic          in_win, acc_ok, sp_ok, pop_en, push_en, wr_en;
  logic          acc_valid, spl_dirty, busy;
  logic [DW-1:0] acc_data, spl_data;

  assign stall_o = busy;
  assign acc_ok  = acc_req_i && !busy;
  assign sp_ok   = sp_set_i && !busy;
  assign d_up    = sp_new_i - sp_q;
  assign d_dn    = sp_q - sp_new_i;
  assign pop_en  = sp_ok && (sp_new_i > sp_q);
  assign push_en = sp_ok && (sp_new_i < sp_q);
  assign len_up  = (d_up >= AW'(DEPTH)) ? (IW+1)'(DEPTH) : d_up[IW:0];
  assign len_dn  = (d_dn >= AW'(DEPTH)) ? (IW+1)'(DEPTH) : d_dn[IW:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= AW'(SP_RESET);
    else if (sp_ok) sp_q <= sp_new_i;
  end

  sww_locate #(.AW(AW), .OW(OW), .DEPTH(DEPTH)) u_loc (
    .sp_i(sp_q), .off_i(acc_off_i), .redir_i(acc_redir_i), .addr_i(acc_addr_i),
    .in_win_o(in_win), .abs_o(abs_addr), .idx_o(acc_idx)
  );

  assign wr_en = acc_ok && acc_we_i && in_win;

  sww_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(acc_idx), .wr_data_i(acc_wdata_i),
    .acc_idx_i(acc_idx), .acc_valid_o(acc_valid), .acc_data_o(acc_data),
    .pop_en_i(pop_en), .pop_base_i(sp_q[IW-1:0]), .pop_len_i(len_up),
    .clr_en_i(busy), .clr_idx_i(spl_idx),
    .clr_dirty_o(spl_dirty), .clr_data_o(spl_data)
  );

  sww_spill #(.AW(AW), .DEPTH(DEPTH)) u_spill (
    .clk_i, .rst_ni,
    .push_en_i(push_en), .push_base_i(sp_q), .push_len_i(len_dn),
    .busy_o(busy), .idx_o(spl_idx), .addr_o(spl_addr)
  );

  assign oor_o         = acc_ok && !in_win;
  assign ld_hit_o      = acc_ok && !acc_we_i && in_win && acc_valid;
  assign ld_data_o     = acc_data;
  assign mem_rd_o      = acc_ok && !acc_we_i && !(in_win && acc_valid);
  assign mem_rd_addr_o = abs_addr;
  assign mem_wr_o      = busy ? spl_dirty : (acc_ok && acc_we_i && !in_win);
  assign mem_wr_addr_o = busy ? spl_addr : abs_addr;
  assign mem_wr_data_o = busy ? spl_data : acc_wdata_i;

  p_stall_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !ld_hit_o && !mem_rd_o && !oor_o);
  p_hit_no_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_hit_o && mem_rd_o));
  p_oor_no_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_o |-> !ld_hit_o);
  p_sp_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stall_o) |-> $stable(sp_q));
endmodule

// File: tb/sim_stack_word_window.sv
module sim_stack_word_window;
  localparam int DEPTH = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sp_set = 0, req = 0, we = 0, redir = 0;
  logic [15:0] sp_new = 0, addr = 0;
  logic [7:0]  off = 0;
  logic [31:0] wdata = 0;
  logic        stall, oor, hit, mrd, mwr;
  logic [31:0] ldata, mwdata;
  logic [15:0] mraddr, mwaddr;

  always #10 clk = ~clk;

  stack_word_window u0 (
    .clk_i(clk), .rst_ni(rst_n), .sp_set_i(sp_set), .sp_new_i(sp_new),
    .acc_req_i(req), .acc_we_i(we), .acc_off_i(off), .acc_redir_i(redir),
    .acc_addr_i(addr), .acc_wdata_i(wdata), .stall_o(stall), .oor_o(oor),
    .ld_hit_o(hit), .ld_data_o(ldata), .mem_rd_o(mrd), .mem_rd_addr_o(mraddr),
    .mem_wr_o(mwr), .mem_wr_addr_o(mwaddr), .mem_wr_data_o(mwdata)
  );

  typedef struct { bit wr; int a; int d; } slot_t;
  slot_t q[$];
  int m_data[int];
  int sp = 'h1000;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit s, int sn, bit r, bit w, int o, bit rd, int ad, int wd);
    bit e_st, e_oor, e_hit, e_rd, e_wr, inw;
    int e_rda, e_wra, e_wd, e_ld, diff, ab;
    @(negedge clk);
    sp_set = s; sp_new = 16'(sn); req = r; we = w; off = 8'(o);
    redir = rd; addr = 16'(ad); wdata = 32'(wd);
    #2;
    e_st = 0; e_oor = 0; e_hit = 0; e_rd = 0; e_wr = 0;
    e_rda = 0; e_wra = 0; e_wd = 0; e_ld = 0;
    diff = rd ? (ad - sp) : o;
    inw = diff >= 0 && diff < DEPTH;
    ab = (sp + diff) & 'hffff;
    if (q.size() > 0) begin
      e_st = 1; e_wr = q[0].wr; e_wra = q[0].a; e_wd = q[0].d;
    end else if (r) begin
      e_oor = !inw;
      if (w) begin
        if (!inw) begin e_wr = 1; e_wra = ab; e_wd = wd; end
      end else if (inw && m_data.exists(ab)) begin
        e_hit = 1; e_ld = m_data[ab];
      end else begin
        e_rd = 1; e_rda = ab;
      end
    end
    chk(tag, "stall_o", int'(stall), int'(e_st));
    chk(tag, "oor_o", int'(oor), int'(e_oor));
    chk(tag, "ld_hit_o", int'(hit), int'(e_hit));
    if (e_hit) chk(tag, "ld_data_o", int'(ldata), e_ld);
    chk(tag, "mem_rd_o", int'(mrd), int'(e_rd));
    if (e_rd) chk(tag, "mem_rd_addr_o", int'(mraddr), e_rda);
    chk(tag, "mem_wr_o", int'(mwr), int'(e_wr));
    if (e_wr) begin
      chk(tag, "mem_wr_addr_o", int'(mwaddr), e_wra);
      chk(tag, "mem_wr_data_o", int'(mwdata), e_wd);
    end
    // model commit for the coming edge
    if (q.size() > 0) void'(q.pop_front());
    else begin
      if (r && w && inw) m_data[ab] = wd;
      if (s && sn > sp) begin
        for (int a = sp; a < sn && a < sp + DEPTH; a++) m_data.delete(a);
      end else if (s && sn < sp) begin
        int dd = sp - sn;
        for (int j = (dd >= DEPTH) ? 0 : DEPTH - dd; j < DEPTH; j++) begin
          slot_t sl;
          sl.a = sp + j; sl.wr = m_data.exists(sp + j);
          sl.d = sl.wr ? m_data[sp + j] : 0;
          m_data.delete(sp + j);
          q.push_back(sl);
        end
      end
      if (s) sp = sn;
    end
  endtask

  task automatic idle(string tag); cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic ld(string tag, int o); cyc(tag, 0, 0, 1, 0, o, 0, 0, 0); endtask
  task automatic st(string tag, int o, int d); cyc(tag, 0, 0, 1, 1, o, 0, 0, d); endtask
  task automatic setsp(string tag, int n); cyc(tag, 1, n, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1'b1;
    // R1 reset state
    idle("R1");
    for (int i = 0; i < 4; i++) ld("R1", i);
    // R2 write-validate, R3 hits
    st("R2", 0, 'h11); st("R2", 1, 'h22); st("R2", 5, 'h55); st("R2", 63, 'h63);
    ld("R3", 0); ld("R3", 1); ld("R3", 5); ld("R3", 63);
    // R4 miss without allocation
    ld("R4", 7); ld("R4", 7);
    // R5 outside the window
    ld("R5", -1); ld("R5", 64); ld("R5", 100); st("R5", -3, 'hABC); st("R5", 64, 'hDEF);
    ld("R5", 63);
    // R8 redirected absolute accesses
    cyc("R8", 0, 0, 1, 1, 0, 1, 'h100A, 'hAA);
    ld("R8", 10);
    cyc("R8", 0, 0, 1, 0, 0, 1, 'h1001, 0);
    cyc("R8", 0, 0, 1, 0, 0, 1, 'h0FFF, 0);
    cyc("R8", 0, 0, 1, 0, 0, 1, 'h1040, 0);
    // R7 push by 4 spills offsets 60..63; R9 inputs ignored during stall
    setsp("R7", 'h0FFC);
    st("R9", 2, 'h999); setsp("R9", 'h0F00); ld("R9", 4); idle("R9");
    idle("R7"); ld("R10", 4); ld("R10", 9); ld("R10", 6);
    // R6 pop frees words, then push back: freed words gone, not written
    st("R6", 0, 'hC0); st("R6", 3, 'hC3);
    setsp("R6", 'h1004);
    ld("R6", 0); ld("R6", 1);
    setsp("R6", 'h0FFC);
    for (int i = 0; i < 4; i++) idle("R6");
    ld("R6", 4); ld("R6", 0); ld("R6", 3); ld("R6", 5);
    // R7 large push scans whole window
    for (int i = 0; i < 8; i++) st("R7", i * 7, 'h700 + i);
    setsp("R7", 'h0F00);
    for (int i = 0; i < DEPTH; i++) idle("R7");
    ld("R7", 0);
    // R6 large pop clears everything
    for (int i = 0; i < 6; i++) st("R6", i * 9, 'h600 + i);
    setsp("R6", 'h1100); setsp("R6", 'h1000);
    for (int i = 0; i < DEPTH; i++) idle("R6");
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int k = int'($urandom_range(0, 9));
      int o = int'($urandom_range(0, 75)) - 4;
      if (k == 0) begin
        int nsp = sp + int'($urandom_range(0, 40)) - 20;
        if (nsp < 'h0800) nsp = 'h0800;
        if (nsp > 'h2000) nsp = 'h2000;
        setsp("R7", nsp);
      end else if (k < 5) st("R2", o, int'($urandom));
      else if (k < 9) ld("R3", o);
      else cyc("R8", 0, 0, 1, 0, 0, 1, sp + o, 0);
    end
    for (int i = 0; i < DEPTH + 2; i++) idle("R7");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule